// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs processor-side transfers on a local bus where the low 16 address bits and the data share one set of lines. A simple internal request (20-bit address, direction, high-byte lane flag, write data) is turned into a bus cycle of at least four clocks. The first clock puts the address out with a latch strobe and a cycle-type status code. The middle clocks assert the read or write strobe and the transceiver enable. The last clock closes the cycle and hands read data back. The cycle can be stretched by a synchronous ready input or by an asynchronous ready input that is synchronized first. The block also drives a direction signal for external data transceivers.

A hold/acknowledge handshake lets another master take the bus between cycles. Every pin group has a separate output-enable, so a "floated" pin is shown by its enable being low. Reset has its own per-pin sequence. The strobes, status and lock are driven inactive for one clock and then released. Every other bus pin is released at once.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, `rd_n`, `wr_n` and `den_n` are high with `strobe_oe` high, `sts` is 3'b111 with `sts_oe` high, and `lock_n` is high with `lock_oe` high, for the first clock after reset is sampled. From the second sampled reset edge on, `strobe_oe`, `sts_oe` and `lock_oe` are low.
- R2: While `rst_n` is low, `ad_oe`, `ahi_oe`, `bhe_oe` and `dtr_oe` are low, and `ale` and `hlda` are low.
- R3: In the first clock of a cycle (T1), `ale` is high for exactly that clock. `ad_out` carries address bits 15:0 with `ad_oe` high, `ahi_out` carries bits 19:16, and `bhe_n` is the inverse of `req_hi_byte`. `sts` is 3'b101 for a read and 3'b110 for a write.
- R4: In a read, from the second clock until the clock in which ready is sampled high, `ad_oe` is low, `rd_n` and `den_n` are low, `wr_n` is high and `dtr` is low.
- R5: In a write, from the second clock until the clock in which ready is sampled high, `ad_out` carries the write data with `ad_oe` high, `wr_n` and `den_n` are low, `rd_n` is high and `dtr` is high.
- R6: With ready high, a cycle takes exactly four clocks. `req_done` is high for one clock, the fourth. In that clock and in idle, the strobes are high and `sts` is 3'b111.
- R7: Each clock edge that ends the third clock or a wait clock with ready low adds one wait clock, during which the strobes stay asserted and `req_done` stays low.
- R8: `srdy` is used at the clock edge where it is sampled. `ardy` passes through a two-flop synchronizer, so a rise on `ardy` ends the cycle two edges later than the same rise on `srdy` would.
- R9: For a read, `ad_in` is captured on the edge that ends the last ready-sampling clock, and it is held on `rsp_rdata` through the fourth clock whatever `ad_in` does afterward.
- R10: `hold` is acted on only in idle or at the end of the fourth clock. One clock follows in which all bus pins are floated and `hlda` is still low. Then `hlda` rises with the pins still floated.
- R11: The first edge that samples `hold` low drops `hlda`. The pins stay floated for that clock and are driven again from the next edge.
- R12: When `hold` and `req_valid` are both high in idle, `hold` wins. The pending request starts its T1 only after the bus is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request, sampled in idle |
| req_addr | input | 20 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_byte | input | 1 | High byte lane enabled |
| req_wdata | input | 16 | Write data |
| req_done | output | 1 | High during the closing clock of a cycle |
| rsp_rdata | output | 16 | Captured read data |
| srdy | input | 1 | Synchronous ready |
| ardy | input | 1 | Asynchronous ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| ad_in | input | 16 | Value seen on the shared address/data lines |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ahi_out | output | 4 | Upper address bits 19:16 |
| ahi_oe | output | 1 | Drive enable for the upper address |
| bhe_n | output | 1 | High byte enable, active low |
| bhe_oe | output | 1 | Drive enable for `bhe_n` |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| strobe_oe | output | 1 | Drive enable for `rd_n`, `wr_n`, `den_n` |
| dtr | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| dtr_oe | output | 1 | Drive enable for `dtr` |
| sts | output | 3 | Cycle status code, 3'b111 = passive |
| sts_oe | output | 1 | Drive enable for `sts` |
| lock_n | output | 1 | Bus lock, active low, held inactive |
| lock_oe | output | 1 | Drive enable for `lock_n` |

## Verification
A sequencer stuck in the wrong state shows at the pins within one clock. `ale` will not be a one-clock pulse, the strobes lose their pairing with the status code, or `req_done` arrives early or late, and each of these is compared against the clock count of the cycle. A miscounted synchronizer or ready path moves `req_done` by whole clocks. A wrong hold state shows as `hlda` rising while the pins are still driven, or as the pins being driven one clock too early after release. A wrong capture edge for read data shows as the wait-state value instead of the final one on `rsp_rdata` in the closing clock.

// File: rtl/lbus_pkg.sv
// Shared types for the multiplexed local bus controller.
// Assumes the sequencer and the pin decoder agree on these encodings.
package lbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4,
        ST_HFLT,
        ST_HELD,
        ST_RSM
    } bus_st_t;

    localparam logic [2:0] STS_PASSIVE = 3'b111;
    localparam logic [2:0] STS_READ    = 3'b101;
    localparam logic [2:0] STS_WRITE   = 3'b110;

endpackage

// File: rtl/lbus_rdy_sync.sv
// Ready combiner: the synchronous ready is used directly, and the
// asynchronous ready passes through a STAGES-deep flop chain first.
// Assumes STAGES >= 1.
module lbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srdy,
    input  logic ardy,
    output logic bus_ready
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw asynchronous ready.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= ardy;
            end
        end else begin : g_next
            // Later stages pass the value one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign bus_ready = srdy | chain[STAGES-1];

endmodule

// File: rtl/lbus_seq.sv
// Bus cycle sequencer: steps T1-T2-T3-(Tw)-T4 and runs the hold handoff.
// It latches the request when a cycle starts and captures read data
// at the edge where ready ends the data phase.
// Assumes req_valid is sampled only in idle and hold only at cycle boundaries.
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_hi_byte,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_ready,
    input  logic              hold,
    input  logic [DATA_W-1:0] ad_in,
    output bus_st_t           st,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic              cur_hi_byte,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    bus_st_t st_nx;
    logic    start;
    logic    data_end;

    assign start    = (st == ST_IDLE) && !hold && req_valid;
    assign data_end = ((st == ST_T3) || (st == ST_TW)) && bus_ready;

    // Next-state choice for the cycle and hold handoff.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (hold)           st_nx = ST_HFLT;
                     else if (req_valid) st_nx = ST_T1;
            ST_T1:   st_nx = ST_T2;
            ST_T2:   st_nx = ST_T3;
            ST_T3,
            ST_TW:   st_nx = bus_ready ? ST_T4 : ST_TW;
            ST_T4:   st_nx = hold ? ST_HFLT : ST_IDLE;
            ST_HFLT: st_nx = ST_HELD;
            ST_HELD: if (!hold) st_nx = ST_RSM;
            ST_RSM:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Request latch, loaded as a cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr    <= '0;
            cur_write   <= 1'b0;
            cur_hi_byte <= 1'b0;
            cur_wdata   <= '0;
        end else if (start) begin
            cur_addr    <= req_addr;
            cur_write   <= req_write;
            cur_hi_byte <= req_hi_byte;
            cur_wdata   <= req_wdata;
        end
    end

    // Read data capture on the edge that closes the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rdata <= '0;
        else if (data_end && !cur_write) rdata <= ad_in;
    end

    assign done = (st == ST_T4);

endmodule

// File: rtl/lbus_pin_drv.sv
// Pin decoder: turns the sequencer state and latched request into pin
// values and drive enables. It also holds the reset drive-then-release
// window for the strobes, status and lock.
// Assumes "floated" is shown by the matching enable being low.
module lbus_pin_drv
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_st_t           st,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_write,
    input  logic              cur_hi_byte,
    input  logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ahi_out,
    output logic              ahi_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              strobe_oe,
    output logic              dtr,
    output logic              dtr_oe,
    output logic [2:0]        sts,
    output logic              sts_oe,
    output logic              lock_n,
    output logic              lock_oe,
    output logic              hlda
);
    logic rst_a;
    logic rst_b;
    logic rst_drive;
    logic in_cycle;
    logic data_ph;
    logic owned;

    // Reset age flops: rst_b is set once reset has lasted two edges.
    always_ff @(posedge clk) begin
        rst_a <= ~rst_n;
        rst_b <= rst_a & ~rst_n;
    end

    assign rst_drive = ~rst_n & ~rst_b;
    assign in_cycle  = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
                       (st == ST_TW) || (st == ST_T4);
    assign data_ph   = (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
    assign owned     = (st != ST_HFLT) && (st != ST_HELD) && (st != ST_RSM);

    // Pin values and enables for reset, owned and released bus.
    always_comb begin
        ad_out    = cur_addr[DATA_W-1:0];
        ad_oe     = 1'b0;
        ahi_out   = cur_addr[ADDR_W-1:DATA_W];
        ahi_oe    = 1'b0;
        bhe_n     = ~cur_hi_byte;
        bhe_oe    = 1'b0;
        ale       = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        den_n     = 1'b1;
        strobe_oe = 1'b0;
        dtr       = 1'b1;
        dtr_oe    = 1'b0;
        sts       = STS_PASSIVE;
        sts_oe    = 1'b0;
        lock_n    = 1'b1;
        lock_oe   = 1'b0;
        hlda      = 1'b0;
        if (!rst_n) begin
            strobe_oe = rst_drive;
            sts_oe    = rst_drive;
            lock_oe   = rst_drive;
        end else if (owned) begin
            strobe_oe = 1'b1;
            sts_oe    = 1'b1;
            lock_oe   = 1'b1;
            dtr_oe    = 1'b1;
            ahi_oe    = in_cycle;
            bhe_oe    = in_cycle;
            dtr       = in_cycle ? cur_write : 1'b1;
            if (st == ST_T1) begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            if (data_ph) begin
                den_n = 1'b0;
                rd_n  = cur_write;
                wr_n  = ~cur_write;
                if (cur_write) begin
                    ad_out = cur_wdata;
                    ad_oe  = 1'b1;
                end
            end
            if ((st == ST_T1) || data_ph)
                sts = cur_write ? STS_WRITE : STS_READ;
        end else begin
            hlda = (st == ST_HELD);
        end
    end

endmodule

// File: rtl/lbus_cycle_ctrl.sv
// Top of the multiplexed local bus controller: ready combining,
// cycle sequencing and pin decoding.
// Assumes a synchronous active-low reset and external tri-state buffers
// controlled by the *_oe outputs.
module lbus_cycle_ctrl #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SYNC_STG = 2,
    localparam int HI_W    = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_hi_byte,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              srdy,
    input  logic              ardy,
    input  logic              hold,
    output logic              hlda,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   ahi_out,
    output logic              ahi_oe,
    output logic              bhe_n,
    output logic              bhe_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              strobe_oe,
    output logic              dtr,
    output logic              dtr_oe,
    output logic [2:0]        sts,
    output logic              sts_oe,
    output logic              lock_n,
    output logic              lock_oe
);
    lbus_pkg::bus_st_t  st;
    logic               bus_ready;
    logic [ADDR_W-1:0]  cur_addr;
    logic               cur_write;
    logic               cur_hi_byte;
    logic [DATA_W-1:0]  cur_wdata;

    lbus_rdy_sync #(.STAGES(SYNC_STG)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .srdy      (srdy),
        .ardy      (ardy),
        .bus_ready (bus_ready)
    );

    lbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_hi_byte (req_hi_byte),
        .req_wdata   (req_wdata),
        .bus_ready   (bus_ready),
        .hold        (hold),
        .ad_in       (ad_in),
        .st          (st),
        .cur_addr    (cur_addr),
        .cur_write   (cur_write),
        .cur_hi_byte (cur_hi_byte),
        .cur_wdata   (cur_wdata),
        .rdata       (rsp_rdata),
        .done        (req_done)
    );

    lbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .st          (st),
        .cur_addr    (cur_addr),
        .cur_write   (cur_write),
        .cur_hi_byte (cur_hi_byte),
        .cur_wdata   (cur_wdata),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ahi_out     (ahi_out),
        .ahi_oe      (ahi_oe),
        .bhe_n       (bhe_n),
        .bhe_oe      (bhe_oe),
        .ale         (ale),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .den_n       (den_n),
        .strobe_oe   (strobe_oe),
        .dtr         (dtr),
        .dtr_oe      (dtr_oe),
        .sts         (sts),
        .sts_oe      (sts_oe),
        .lock_n      (lock_n),
        .lock_oe     (lock_oe),
        .hlda        (hlda)
    );

endmodule

// File: rtl/lbus_chk.sv
// Port-level protocol checker for lbus_cycle_ctrl, attached by bind.
module lbus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_done,
    input logic       hlda,
    input logic       ad_oe,
    input logic       ahi_oe,
    input logic       bhe_oe,
    input logic       dtr_oe,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       strobe_oe,
    input logic [2:0] sts,
    input logic       sts_oe
);
    // Reset releases the address, byte enable and direction pins (R2).
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_float_r2: assert (!ad_oe && !ahi_oe && !bhe_oe && !dtr_oe && !ale && !hlda)
                else $error("reset pins not released");
        end
    end

    p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_ale_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (sts != 3'b111));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_done_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> $past(!rd_n || !wr_n));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    p_held_floated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !strobe_oe && !sts_oe && !ahi_oe));

    p_float_before_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(!strobe_oe && !ad_oe));

    p_release_floated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda) |-> !strobe_oe);

endmodule

bind lbus_cycle_ctrl lbus_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_done  (req_done),
    .hlda      (hlda),
    .ad_oe     (ad_oe),
    .ahi_oe    (ahi_oe),
    .bhe_oe    (bhe_oe),
    .dtr_oe    (dtr_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .strobe_oe (strobe_oe),
    .sts       (sts),
    .sts_oe    (sts_oe)
);

// File: tb/sim_lbus_cycle_ctrl.sv
// Directed bench for lbus_cycle_ctrl: one task per scenario.
module sim_lbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_hi_byte = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_done;
    logic [15:0] rsp_rdata;
    logic        srdy = 1'b1;
    logic        ardy = 1'b0;
    logic        hold = 1'b0;
    logic        hlda;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  ahi_out;
    logic        ahi_oe, bhe_n, bhe_oe, ale, rd_n, wr_n, den_n, strobe_oe;
    logic        dtr, dtr_oe, sts_oe, lock_n, lock_oe;
    logic [2:0]  sts;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lbus_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_hi_byte(req_hi_byte), .req_wdata(req_wdata),
        .req_done(req_done), .rsp_rdata(rsp_rdata), .srdy(srdy), .ardy(ardy),
        .hold(hold), .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ahi_out(ahi_out), .ahi_oe(ahi_oe), .bhe_n(bhe_n), .bhe_oe(bhe_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .strobe_oe(strobe_oe),
        .dtr(dtr), .dtr_oe(dtr_oe), .sts(sts), .sts_oe(sts_oe),
        .lock_n(lock_n), .lock_oe(lock_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue a request from idle; returns in the T1 clock with valid dropped.
    task automatic begin_cycle(input logic [19:0] a, input logic w,
                               input logic hi, input logic [15:0] d);
        @(negedge clk);
        req_addr = a; req_write = w; req_hi_byte = hi; req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_powerup_reset;
        repeat (2) @(negedge clk);
        chk("R1", "strobe_oe after 2 edges", strobe_oe, 0);
        chk("R1", "sts_oe after 2 edges", sts_oe, 0);
        chk("R1", "lock_oe after 2 edges", lock_oe, 0);
        chk("R2", "ad/ahi/bhe/dtr oe", {ad_oe, ahi_oe, bhe_oe, dtr_oe}, 0);
        chk("R2", "ale,hlda", {ale, hlda}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "idle strobes driven high", {strobe_oe, rd_n, wr_n, den_n}, 4'b1111);
        chk("R6", "idle status passive", {sts_oe, sts}, 4'b1111);
        chk("R6", "idle done low", req_done, 0);
    endtask

    task automatic t_reset_midrun;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "first reset clock strobes", {strobe_oe, rd_n, wr_n, den_n}, 4'b1111);
        chk("R1", "first reset clock status", {sts_oe, sts}, 4'b1111);
        chk("R1", "first reset clock lock", {lock_oe, lock_n}, 2'b11);
        chk("R2", "first reset clock floats", {ad_oe, ahi_oe, bhe_oe, dtr_oe, ale, hlda}, 0);
        @(negedge clk);
        chk("R1", "second reset clock released", {strobe_oe, sts_oe, lock_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "idle after reset", {strobe_oe, sts}, 4'b1111);
    endtask

    task automatic t_read_basic;
        srdy = 1'b1;
        begin_cycle(20'hA5C3E, 1'b0, 1'b1, 16'h0000);
        chk("R3", "ale in T1", ale, 1);
        chk("R3", "address low in T1", {ad_oe, ad_out}, {1'b1, 16'h5C3E});
        chk("R3", "address high in T1", {ahi_oe, ahi_out}, {1'b1, 4'hA});
        chk("R3", "bhe_n in T1", {bhe_oe, bhe_n}, 2'b10);
        chk("R3", "read status", sts, 3'b101);
        @(negedge clk);
        ad_in = 16'h1234;
        chk("R4", "T2 lines floated", ad_oe, 0);
        chk("R4", "T2 read strobes", {rd_n, wr_n, den_n, dtr}, 4'b0100);
        chk("R3", "ale dropped after T1", ale, 0);
        @(negedge clk);
        chk("R4", "T3 read strobe", {rd_n, den_n}, 2'b00);
        chk("R6", "T3 not done", req_done, 0);
        @(negedge clk);
        chk("R6", "T4 done", req_done, 1);
        chk("R6", "T4 strobes idle", {rd_n, den_n, sts}, 5'b11111);
        chk("R9", "read data", rsp_rdata, 16'h1234);
        @(negedge clk);
        chk("R6", "done single clock", req_done, 0);
    endtask

    task automatic t_write_basic;
        begin_cycle(20'h3F001, 1'b1, 1'b0, 16'hBEEF);
        chk("R3", "write status", sts, 3'b110);
        chk("R3", "address low write", ad_out, 16'hF001);
        chk("R3", "bhe_n inactive", bhe_n, 1);
        @(negedge clk);
        chk("R5", "T2 write data", {ad_oe, ad_out}, {1'b1, 16'hBEEF});
        chk("R5", "T2 write strobes", {rd_n, wr_n, den_n, dtr}, 4'b1001);
        @(negedge clk);
        chk("R5", "T3 write strobe", wr_n, 0);
        @(negedge clk);
        chk("R6", "write T4 done", {req_done, wr_n}, 2'b11);
        @(negedge clk);
    endtask

    task automatic t_sync_wait;
        srdy = 1'b0;
        begin_cycle(20'h00100, 1'b0, 1'b1, 16'h0);
        @(negedge clk);
        ad_in = 16'hAAAA;
        @(negedge clk);
        chk("R7", "T3 with ready low", req_done, 0);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            chk("R7", "wait clock strobes held", {rd_n, den_n, req_done}, 3'b000);
            if (i == 3) begin
                srdy = 1'b1;
                ad_in = 16'h5A5A;
            end
        end
        @(negedge clk);
        chk("R7", "done after three waits", req_done, 1);
        chk("R9", "captured final value", rsp_rdata, 16'h5A5A);
        ad_in = 16'hFFFF;
        #1;
        chk("R9", "held after bus change", rsp_rdata, 16'h5A5A);
        @(negedge clk);
    endtask

    task automatic t_ready_paths;
        srdy = 1'b0;
        ardy = 1'b0;
        begin_cycle(20'h00200, 1'b0, 1'b0, 16'h0);
        repeat (2) @(negedge clk);
        srdy = 1'b1;
        @(negedge clk);
        chk("R8", "srdy ends cycle next edge", req_done, 1);
        srdy = 1'b0;
        @(negedge clk);
        begin_cycle(20'h00300, 1'b0, 1'b0, 16'h0);
        repeat (2) @(negedge clk);
        ardy = 1'b1;
        @(negedge clk);
        chk("R8", "ardy first sync clock", req_done, 0);
        @(negedge clk);
        chk("R8", "ardy second sync clock", req_done, 0);
        @(negedge clk);
        chk("R8", "ardy ends cycle", req_done, 1);
        ardy = 1'b0;
        srdy = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_hold_idle;
        @(negedge clk);
        hold = 1'b1;
        req_addr = 20'h7_1357; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        chk("R12", "no T1 while hold", ale, 0);
        chk("R10", "float clock before grant", {hlda, strobe_oe, ad_oe, sts_oe}, 0);
        @(negedge clk);
        chk("R10", "granted", {hlda, strobe_oe, ahi_oe}, 3'b100);
        @(negedge clk);
        chk("R12", "still held, no cycle", {hlda, ale}, 2'b10);
        hold = 1'b0;
        @(negedge clk);
        chk("R11", "hlda drops, still floated", {hlda, strobe_oe, ale}, 0);
        @(negedge clk);
        chk("R11", "driving again", {strobe_oe, ale}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12", "pending request T1", {ale, ad_out}, {1'b1, 16'h1357});
        repeat (3) @(negedge clk);
        chk("R12", "pending request done", req_done, 1);
        @(negedge clk);
    endtask

    task automatic t_hold_midcycle;
        begin_cycle(20'h12345, 1'b1, 1'b1, 16'hC0DE);
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk("R10", "cycle continues under hold", {hlda, wr_n}, 2'b00);
        @(negedge clk);
        chk("R10", "cycle completes under hold", {req_done, hlda}, 2'b10);
        @(negedge clk);
        chk("R10", "float clock after cycle", {hlda, strobe_oe, ad_oe, sts_oe}, 0);
        @(negedge clk);
        chk("R10", "granted after cycle", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        chk("R11", "release clock floated", {hlda, strobe_oe}, 0);
        @(negedge clk);
        chk("R11", "bus driven after release", {strobe_oe, sts}, 4'b1111);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_powerup_reset();
        t_read_basic();
        t_write_basic();
        t_sync_wait();
        t_ready_paths();
        t_hold_idle();
        t_hold_midcycle();
        t_reset_midrun();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule